// File: doc/BRIEF.md
# Register Control Bus with Request/Acknowledge Handshake

This block carries register accesses from one processor-side master to a set of control-register slaves. It uses a 10-bit address and a 32-bit data word. A local command (read or write, address, write data) starts an access. The master raises a read or write request line and holds the address and write data steady. The access completes only when an acknowledge comes back. The master then drops its request, waits until the acknowledge falls, and reports completion with a one-cycle pulse. This four-phase exchange lets the slaves run on a clock that is unrelated to the master clock, faster or slower. Both the request and the acknowledge cross between the domains through two-flop synchronisers.

The slaves sit in a daisy chain. Each slave forwards the acknowledge and read data from its upstream neighbour. Only the slave whose address window matches drives its own acknowledge and puts its own register contents onto the data path. The master therefore sees a single acknowledge and a single data word at the end of the chain.

If no slave answers within a fixed number of master cycles, the master ends the access. It raises a timeout flag and returns all ones.

Top module: `ctrl_reg_bus`

## Requirements
- R1: Addresses are 10 bits and data words are 32 bits. When `cmd_rd` and `cmd_wr` are both high at acceptance, a read is performed and no register changes. The internal read and write request lines are never high together.
- R2: After reset, `cmd_busy` and `done` are 0. A command accepted while idle raises `cmd_busy` on the next cycle. `done` is a pulse of exactly one master cycle. Every access takes at least 2 master cycles from acceptance to `done`.
- R3: While a request line is held, the address and write data presented to the slaves do not change.
- R4: The handshake is four-phase. The master drops its request in the cycle after it sees the synchronised acknowledge. It signals `done` only after the synchronised acknowledge has fallen again.
- R5: Slave k (k = 0 to N_SLAVES-1) answers only when BASE0 + k*STRIDE <= address < BASE0 + k*STRIDE + RANGE. With the defaults (BASE0 = 0x040, STRIDE = 0x020, RANGE = 4), the windows are 0x040-0x043, 0x060-0x063 and 0x080-0x083. Any other address gets no answer.
- R6: A read returns the addressed register through the chain, whatever the slave's position in the chain. Register index i of slave k resets to 0xA5000000 | (k << 8) | i.
- R7: A write updates exactly the addressed register, once per access. For a completed write, `done_rdata` is 0 and `done_timeout` is 0.
- R8: If no acknowledge arrives within TIMEOUT_CYC (64) master cycles, the access ends with `done_timeout` = 1 and `done_rdata` = 0xFFFFFFFF. The access takes at least 64 cycles, and no register changes.
- R9: Accesses complete correctly both when the slave clock is slower than the master clock and when it is faster.
- R10: A command presented while `cmd_busy` is high is ignored and causes no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock |
| rst_m_n | input | 1 | Master-domain asynchronous active-low reset |
| clk_s | input | 1 | Slave clock |
| rst_s_n | input | 1 | Slave-domain asynchronous active-low reset |
| cmd_rd | input | 1 | Start a read (sampled while idle) |
| cmd_wr | input | 1 | Start a write (sampled while idle) |
| cmd_addr | input | 10 | Register address of the command |
| cmd_wdata | input | 32 | Write data of the command |
| cmd_busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | 32 | Read data, 0 after a write, all ones after a timeout |
| done_timeout | output | 1 | The last access received no acknowledge |

## Verification
The bench reads the addresses just inside and just outside each slave window. A decoder with an off-by-one error would either answer at base+range, where the bench expects a timeout, or stay silent at the last valid index, where it expects data. A write to an unmapped address and a command issued while busy are each followed by reads of nearby registers, so a stray or duplicated write shows up as corrupted data. A simultaneous read/write command and runs with both a slow and a fast slave clock expose wrong command priority and handshake races. A master that reported `done` before the acknowledge fell would leave a stale acknowledge behind, and the access that follows would then complete with wrong data.

// File: rtl/ctrlbus_pkg.sv
`timescale 1ns/1ps
package ctrlbus_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic [1:0] {
    M_IDLE    = 2'd0,
    M_REQ     = 2'd1,
    M_RELEASE = 2'd2
  } mstate_e;
endpackage

// File: rtl/cb_sync2.sv
`timescale 1ns/1ps
// Two-flop synchroniser; also used as a reset synchroniser with d tied high.
module cb_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/cb_master.sv
`timescale 1ns/1ps
module cb_master
  import ctrlbus_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cmd_rd,
  input  logic  cmd_wr,
  input  addr_t cmd_addr,
  input  data_t cmd_wdata,
  output logic  cmd_busy,
  output logic  done,
  output data_t done_rdata,
  output logic  done_timeout,
  output logic  bus_rd,
  output logic  bus_wr,
  output addr_t bus_addr,
  output data_t bus_wdata,
  input  logic  ack_sync,
  input  data_t chain_rdata
);
  localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  mstate_e          st_q, st_n;
  logic             rd_n, wr_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cmd_en;
  logic             res_en;
  data_t            res_data_n;
  logic             res_to_n;
  logic             done_n;

  // next-state logic
  always_comb begin
    st_n       = st_q;
    rd_n       = bus_rd;
    wr_n       = bus_wr;
    cnt_n      = cnt_q;
    cmd_en     = 1'b0;
    res_en     = 1'b0;
    res_data_n = '0;
    res_to_n   = 1'b0;
    done_n     = 1'b0;
    unique case (st_q)
      M_IDLE: begin
        if (cmd_rd || cmd_wr) begin
          st_n   = M_REQ;
          rd_n   = cmd_rd;
          wr_n   = !cmd_rd;
          cnt_n  = '0;
          cmd_en = 1'b1;
        end
      end
      M_REQ: begin
        if (ack_sync) begin
          st_n       = M_RELEASE;
          rd_n       = 1'b0;
          wr_n       = 1'b0;
          res_en     = 1'b1;
          res_data_n = bus_rd ? chain_rdata : '0;
          res_to_n   = 1'b0;
        end else if (cnt_q == CNT_LAST) begin
          st_n       = M_RELEASE;
          rd_n       = 1'b0;
          wr_n       = 1'b0;
          res_en     = 1'b1;
          res_data_n = '1;
          res_to_n   = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      M_RELEASE: begin
        if (!ack_sync) begin
          st_n   = M_IDLE;
          done_n = 1'b1;
        end
      end
      default: st_n = M_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= M_IDLE;
      bus_rd <= 1'b0;
      bus_wr <= 1'b0;
      cnt_q  <= '0;
      done   <= 1'b0;
    end else begin
      st_q   <= st_n;
      bus_rd <= rd_n;
      bus_wr <= wr_n;
      cnt_q  <= cnt_n;
      done   <= done_n;
    end
  end

  // command latch, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else if (cmd_en) begin
      bus_addr  <= cmd_addr;
      bus_wdata <= cmd_wdata;
    end
  end

  // result registers, enabled when the request phase ends
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_rdata   <= '0;
      done_timeout <= 1'b0;
    end else if (res_en) begin
      done_rdata   <= res_data_n;
      done_timeout <= res_to_n;
    end
  end

  assign cmd_busy = (st_q != M_IDLE);
endmodule

// File: rtl/cb_slave.sv
`timescale 1ns/1ps
module cb_slave
  import ctrlbus_pkg::*;
#(
  parameter int BASE     = 64,
  parameter int RANGE    = 4,
  parameter int SLAVE_ID = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bus_rd,
  input  logic  bus_wr,
  input  addr_t bus_addr,
  input  data_t bus_wdata,
  input  logic  ack_in,
  input  data_t data_in,
  output logic  ack_out,
  output data_t data_out
);
  localparam int IDX_W = (RANGE > 1) ? $clog2(RANGE) : 1;
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(BASE + RANGE);

  logic [1:0]       req_s;
  logic             wr_s, req_now, req_q, start, hit, wr_en;
  logic             own_ack_q, own_ack_n;
  data_t            own_q, own_n;
  logic             own_en;
  logic [IDX_W-1:0] idx;
  data_t            regs [RANGE];

  cb_sync2 #(.W(2)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_rd, bus_wr}),
    .q     (req_s)
  );

  assign wr_s    = req_s[0];
  assign req_now = |req_s;
  assign start   = req_now && !req_q;
  assign hit     = ({1'b0, bus_addr} >= WIN_LO) && ({1'b0, bus_addr} < WIN_HI);
  assign idx     = IDX_W'(bus_addr - ADDR_W'(BASE));
  assign wr_en   = start && hit && wr_s;

  always_comb begin
    own_ack_n = own_ack_q;
    own_en    = 1'b0;
    own_n     = own_q;
    if (start && hit) begin
      own_ack_n = 1'b1;
      own_en    = 1'b1;
      own_n     = wr_s ? bus_wdata : regs[idx];
    end else if (!req_now) begin
      own_ack_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      own_ack_q <= 1'b0;
    end else begin
      req_q     <= req_now;
      own_ack_q <= own_ack_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0;
    end else if (own_en) begin
      own_q <= own_n;
    end
  end

  for (genvar i = 0; i < RANGE; i++) begin : g_reg
    localparam data_t RST_VAL = DATA_W'(32'hA500_0000 | (SLAVE_ID << 8) | i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[i] <= RST_VAL;
      end else if (wr_en && (idx == IDX_W'(i))) begin
        regs[i] <= bus_wdata;
      end
    end
  end

  // chain pass-through: substitute own response only when selected
  assign ack_out  = ack_in | own_ack_q;
  assign data_out = own_ack_q ? own_q : data_in;
endmodule

// File: rtl/ctrl_reg_bus.sv
`timescale 1ns/1ps
module ctrl_reg_bus
  import ctrlbus_pkg::*;
#(
  parameter int N_SLAVES    = 3,
  parameter int BASE0       = 64,
  parameter int STRIDE      = 32,
  parameter int RANGE       = 4,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic        clk_m,
  input  logic        rst_m_n,
  input  logic        clk_s,
  input  logic        rst_s_n,
  input  logic        cmd_rd,
  input  logic        cmd_wr,
  input  logic [9:0]  cmd_addr,
  input  logic [31:0] cmd_wdata,
  output logic        cmd_busy,
  output logic        done,
  output logic [31:0] done_rdata,
  output logic        done_timeout
);
  logic  rst_m_sync, rst_s_sync;
  logic  bus_rd, bus_wr;
  addr_t bus_addr;
  data_t bus_wdata;
  logic  ack_m;
  logic  ack_c  [N_SLAVES+1];
  data_t data_c [N_SLAVES+1];

  cb_sync2 #(.W(1)) u_rst_m (
    .clk (clk_m), .rst_n (rst_m_n), .d (1'b1), .q (rst_m_sync)
  );
  cb_sync2 #(.W(1)) u_rst_s (
    .clk (clk_s), .rst_n (rst_s_n), .d (1'b1), .q (rst_s_sync)
  );

  cb_master #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_master (
    .clk          (clk_m),
    .rst_n        (rst_m_sync),
    .cmd_rd       (cmd_rd),
    .cmd_wr       (cmd_wr),
    .cmd_addr     (cmd_addr),
    .cmd_wdata    (cmd_wdata),
    .cmd_busy     (cmd_busy),
    .done         (done),
    .done_rdata   (done_rdata),
    .done_timeout (done_timeout),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .ack_sync     (ack_m),
    .chain_rdata  (data_c[N_SLAVES])
  );

  assign ack_c[0]  = 1'b0;
  assign data_c[0] = '0;

  for (genvar k = 0; k < N_SLAVES; k++) begin : g_slave
    cb_slave #(
      .BASE     (BASE0 + k * STRIDE),
      .RANGE    (RANGE),
      .SLAVE_ID (k)
    ) u_slave (
      .clk       (clk_s),
      .rst_n     (rst_s_sync),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .ack_in    (ack_c[k]),
      .data_in   (data_c[k]),
      .ack_out   (ack_c[k+1]),
      .data_out  (data_c[k+1])
    );
  end

  cb_sync2 #(.W(1)) u_ack_sync (
    .clk (clk_m), .rst_n (rst_m_sync), .d (ack_c[N_SLAVES]), .q (ack_m)
  );
endmodule

// File: rtl/ctrl_reg_bus_chk.sv
`timescale 1ns/1ps
module ctrl_reg_bus_chk (
  input logic        clk_m,
  input logic        rst_m_n,
  input logic        cmd_busy,
  input logic        done,
  input logic [31:0] done_rdata,
  input logic        done_timeout,
  input logic        m_rd,
  input logic        m_wr,
  input logic [9:0]  m_addr,
  input logic [31:0] m_wdata,
  input logic        ack_m
);
  a_r1_req_exclusive: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    !(m_rd && m_wr));

  a_r2_req_implies_busy: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    (m_rd || m_wr) |-> cmd_busy);

  a_r2_done_one_cycle: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    done |=> !done);

  a_r3_addr_held: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    ((m_rd || m_wr) && $past(m_rd || m_wr)) |-> ($stable(m_addr) && $stable(m_wdata)));

  a_r4_drop_after_ack: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    (ack_m && (m_rd || m_wr)) |=> !(m_rd || m_wr));

  a_r4_done_after_ack_low: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    done |-> !$past(ack_m));

  a_r8_timeout_all_ones: assert property (@(posedge clk_m) disable iff (!rst_m_n)
    (done && done_timeout) |-> (&done_rdata));
endmodule

bind ctrl_reg_bus ctrl_reg_bus_chk chk_i (
  .clk_m        (clk_m),
  .rst_m_n      (rst_m_n),
  .cmd_busy     (cmd_busy),
  .done         (done),
  .done_rdata   (done_rdata),
  .done_timeout (done_timeout),
  .m_rd         (bus_rd),
  .m_wr         (bus_wr),
  .m_addr       (bus_addr),
  .m_wdata      (bus_wdata),
  .ack_m        (ack_m)
);

// File: tb/ctrl_reg_bus_tb.sv
`timescale 1ns/1ps
module ctrl_reg_bus_tb_top;
  localparam int NS    = 3;
  localparam int BASE0 = 64;
  localparam int STRD  = 32;
  localparam int RNG   = 4;

  logic        clk_m = 1'b0;
  logic        clk_s = 1'b0;
  logic        rst_m_n, rst_s_n;
  logic        cmd_rd, cmd_wr;
  logic [9:0]  cmd_addr;
  logic [31:0] cmd_wdata;
  logic        cmd_busy, done, done_timeout;
  logic [31:0] done_rdata;

  int    errors = 0;
  int    checks = 0;
  real   s_half = 7.0;
  bit    finished = 1'b0;

  logic [31:0] model [NS][RNG];
  logic [31:0] exp_data_q [$];
  logic        exp_to_q   [$];
  string       tag_q      [$];

  ctrl_reg_bus dut_i (
    .clk_m (clk_m), .rst_m_n (rst_m_n), .clk_s (clk_s), .rst_s_n (rst_s_n),
    .cmd_rd (cmd_rd), .cmd_wr (cmd_wr), .cmd_addr (cmd_addr), .cmd_wdata (cmd_wdata),
    .cmd_busy (cmd_busy), .done (done), .done_rdata (done_rdata),
    .done_timeout (done_timeout)
  );

  always #5 clk_m = ~clk_m;
  always #(s_half) clk_s = ~clk_s;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns slave index or -1; idx is the register within the slave
  function automatic int decode(input logic [9:0] a, output int idx);
    idx = 0;
    for (int k = 0; k < NS; k++) begin
      if (int'(a) >= BASE0 + k*STRD && int'(a) < BASE0 + k*STRD + RNG) begin
        idx = int'(a) - (BASE0 + k*STRD);
        return k;
      end
    end
    return -1;
  endfunction

  // driver: push expectation, present one command, wait for completion
  task automatic access(input bit rd, input bit wr, input logic [9:0] a,
                        input logic [31:0] wd, input string tag);
    int k, idx, cyc;
    logic [31:0] ed;
    logic        et;
    k = decode(a, idx);
    if (k < 0) begin
      ed = 32'hFFFF_FFFF; et = 1'b1;
    end else if (rd) begin
      ed = model[k][idx]; et = 1'b0;
    end else begin
      ed = 32'h0; et = 1'b0;
      model[k][idx] = wd;
    end
    @(negedge clk_m);
    while (cmd_busy) @(negedge clk_m);
    exp_data_q.push_back(ed); exp_to_q.push_back(et); tag_q.push_back(tag);
    cmd_rd = rd; cmd_wr = wr; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk_m);
    cmd_rd = 1'b0; cmd_wr = 1'b0;
    check(cmd_busy == 1'b1, "R2 busy after accept", 32'(cmd_busy), 32'd1);
    cyc = 1;
    while (cmd_busy) begin
      @(negedge clk_m);
      cyc++;
    end
    check(cyc >= 2, "R2 min two cycles", 32'(cyc), 32'd2);
    if (k < 0)
      check(cyc >= 64, "R8 timeout length", 32'(cyc), 32'd64);
  endtask

  // monitor: compare each completion with the head of the queue
  initial begin
    forever begin
      @(negedge clk_m);
      if (done) begin
        if (exp_data_q.size() == 0) begin
          check(1'b0, "R2 unexpected done", 32'h0, 32'h0);
        end else begin
          logic [31:0] ed;
          logic        et;
          string       tg;
          ed = exp_data_q.pop_front(); et = exp_to_q.pop_front(); tg = tag_q.pop_front();
          check(done_rdata == ed, {tg, " data"}, done_rdata, ed);
          check(done_timeout == et, {tg, " timeout"}, 32'(done_timeout), 32'(et));
        end
      end
    end
  end

  task automatic read_all(input string tag);
    for (int k = 0; k < NS; k++)
      for (int i = 0; i < RNG; i++)
        access(1'b1, 1'b0, 10'(BASE0 + k*STRD + i), 32'h0, tag);
  endtask

  initial begin
    for (int k = 0; k < NS; k++)
      for (int i = 0; i < RNG; i++)
        model[k][i] = 32'hA500_0000 | 32'(k << 8) | 32'(i);
    rst_m_n = 1'b0; rst_s_n = 1'b0;
    cmd_rd = 1'b0; cmd_wr = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    repeat (4) @(negedge clk_m);
    rst_m_n = 1'b1; rst_s_n = 1'b1;
    repeat (4) @(negedge clk_m);
    check(cmd_busy == 1'b0, "R2 reset busy", 32'(cmd_busy), 32'd0);
    check(done == 1'b0, "R2 reset done", 32'(done), 32'd0);

    // slow slave clock
    read_all("R6 reset values");
    access(1'b0, 1'b1, 10'h062, 32'h1234_5678, "R7 write s1");
    access(1'b1, 1'b0, 10'h062, 32'h0, "R7 readback s1");
    access(1'b0, 1'b1, 10'h040, 32'hDEAD_BEEF, "R7 write s0 first");
    access(1'b0, 1'b1, 10'h083, 32'h0BAD_F00D, "R7 write s2 last");
    access(1'b1, 1'b0, 10'h083, 32'h0, "R5 last index hit");
    access(1'b1, 1'b0, 10'h044, 32'h0, "R5 R8 just past window");
    access(1'b1, 1'b0, 10'h03F, 32'h0, "R5 just below window");
    access(1'b0, 1'b1, 10'h064, 32'h5555_AAAA, "R8 write unmapped");
    access(1'b1, 1'b1, 10'h060, 32'h7777_7777, "R1 rd and wr together");
    read_all("R8 R1 no change");

    // command while busy is ignored
    begin
      access_busy_probe();
    end
    access(1'b1, 1'b0, 10'h081, 32'h0, "R10 ignored while busy");

    // fast slave clock
    s_half = 2.0;
    repeat (10) @(negedge clk_m);
    access(1'b0, 1'b1, 10'h041, 32'hCAFE_0001, "R9 fast write");
    access(1'b0, 1'b1, 10'h082, 32'hCAFE_0002, "R9 fast write");
    access(1'b1, 1'b0, 10'h043, 32'h0, "R9 fast timeout neighbour");
    access(1'b1, 1'b0, 10'h084, 32'h0, "R9 fast unmapped");
    read_all("R9 fast read");

    repeat (5) @(negedge clk_m);
    check(exp_data_q.size() == 0, "R2 all completions seen",
          32'(exp_data_q.size()), 32'd0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // start a read, then present a write to 0x081 while busy (R10)
  task automatic access_busy_probe();
    exp_data_q.push_back(model[0][2]); exp_to_q.push_back(1'b0);
    tag_q.push_back("R10 probe read");
    @(negedge clk_m);
    while (cmd_busy) @(negedge clk_m);
    cmd_rd = 1'b1; cmd_addr = 10'h042;
    @(negedge clk_m);
    cmd_rd = 1'b0;
    @(negedge clk_m);
    check(cmd_busy == 1'b1, "R10 busy during probe", 32'(cmd_busy), 32'd1);
    cmd_wr = 1'b1; cmd_addr = 10'h081; cmd_wdata = 32'h1111_2222;
    @(negedge clk_m);
    cmd_wr = 1'b0;
    while (cmd_busy) @(negedge clk_m);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk_m);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R2 actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule